// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the command side of a byte-level SPI NOR flash slave. A serial front end hands it one received byte per strobe while chip select is active, and it hands back one response byte for that strobe. The sequencer decodes the first byte of each selected frame as an opcode. It then gathers the address, dummy and parameter bytes that the opcode needs. After that it streams array data for a read, forwards each written byte to the array engine for a page program, issues an erase request, or returns register bytes such as status, flag status, device ID, volatile configuration and the extended segment register.

The block owns the write-enable latch, the 3-byte or 4-byte address mode, the extended segment register, the volatile configuration byte and the reset-enable flag. The flash array is not inside it. Read data comes back combinationally from an external engine at the address the sequencer presents. Program and erase requests go out as single-cycle pulses. Dummy clocks are counted as whole bytes, and only single-lane transfers are modelled.

Top module: `spi_nor_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle with `tx_byte` = 0x00. The write-enable latch, 4-byte mode and extended segment register are all 0, and the volatile configuration equals `VCFG_RST`.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Status read (0x05) returns a byte whose bit 1 is the latch and whose other bits are 0.
- R3: Opcode 0xB7 selects 4-byte addressing and 0xE9 returns to 3-byte addressing. Flag status read (0x70) returns bit 7 = 1 (ready) and bit 0 = 4-byte mode, with all other bits 0.
- R4: In 3-byte mode the effective address is the extended segment register times 2^24 plus the 24-bit received address. Opcode 0xC8 reads the register. Opcode 0xC5 with one parameter byte writes it, but only while the write-enable latch is set.
- R5: Read (0x03) takes the address bytes (most significant first) and then returns the array byte at the current address on each strobe. Each strobe advances the address by one, modulo 2^`SIZE_LOG2`.
- R6: Fast read (0x0B) takes the address bytes followed by N ignored dummy bytes, where N is bits [7:4] of the volatile configuration. Opcode 0x81 writes that byte while write enable is set, and 0x85 reads it.
- R7: ID read (0x9F) streams the `ID_LEN` most significant bytes of `ID_BYTES`, highest byte first, and then returns 0x00.
- R8: Reset (0x99) takes effect only when the opcode of the frame just before it was 0x66. Any other opcode clears the reset-enable flag. An accepted reset restores the R1 register values.
- R9: Opcode 0x01, while write enable is set, collects one or two bytes. Byte 0 goes to the volatile configuration, and bit 5 of byte 1 sets the address mode. The bytes are committed on the second byte, or when chip select drops after only one byte.
- R10: Sector erase 0xD8 (current address length) and 0xDC (always 4 address bytes) pulse `erase_valid` with the effective address on the last address byte, only while write enable is set.
- R11: Page program (0x02) with write enable set pulses `prog_valid` for each data byte after the address, at consecutive addresses. Without write enable, no pulse occurs.
- R12: After a frame's command has finished, and for unknown opcodes, further bytes are ignored until chip select drops. Dropping chip select always returns the sequencer to idle.
- R13: The response to a strobe is the value the state presents before that strobe is processed. Idle and byte-collection states return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select, 1 = device selected |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response byte for the current strobe |
| mem_addr | output | SIZE_LOG2 | Current array address for read and program |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| prog_valid | output | 1 | Program one byte at `mem_addr` |
| prog_data | output | 8 | Byte to program |
| erase_valid | output | 1 | Sector erase request |
| erase_addr | output | SIZE_LOG2 | Address inside the sector to erase |

## Verification
The assertions assume that `rx_valid` is only meaningful while `cs_active` is high. They also assume that `mem_rdata` is a pure function of `mem_addr` within a cycle, and that chip select drops for at least one clock between frames. The bench always drives a strobe for exactly one clock, holding `cs_active` high across it, and ends every frame with one or more low chip-select clocks. Array data comes from an arithmetic function of the address, so every streamed byte has a computable expected value, including across the wrap at the top of the address space.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_RDFSR = 8'h70;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_SE4   = 8'hDC;
    localparam logic [7:0] OP_EN4   = 8'hB7;
    localparam logic [7:0] OP_EX4   = 8'hE9;
    localparam logic [7:0] OP_RDSEG = 8'hC8;
    localparam logic [7:0] OP_WRSEG = 8'hC5;
    localparam logic [7:0] OP_RDVC  = 8'h85;
    localparam logic [7:0] OP_WRVC  = 8'h81;
    localparam logic [7:0] OP_WRSC  = 8'h01;
    localparam logic [7:0] OP_RSTEN = 8'h66;
    localparam logic [7:0] OP_RST   = 8'h99;

    localparam int REG_BYTES = 6;
    localparam int REG_W     = 8 * REG_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE, ST_COLLECT, ST_COLLECT_VAR, ST_REG_OUT, ST_PROGRAM, ST_READ
    } seq_state_e;

    typedef enum logic [1:0] {GO_NONE, GO_COLLECT, GO_VAR, GO_REGS} go_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_READ, ACT_PROG, ACT_ERASE, ACT_SEG, ACT_VCFG, ACT_STATUS
    } act_e;

    typedef struct packed {
        go_e              go;
        act_e             act;
        logic [4:0]       need;
        logic [2:0]       keep;
        logic             a4;
        logic [2:0]       rlen;
        logic [REG_W-1:0] rbytes;
        logic             wel_set;
        logic             wel_clr;
        logic             a4_set;
        logic             a4_clr;
        logic             rsten_req;
        logic             sreset_req;
    } dec_t;

    function automatic logic [4:0] addr_bytes(input logic four);
        return four ? 5'd4 : 5'd3;
    endfunction

endpackage

// File: rtl/spi_nor_opdecode.sv
module spi_nor_opdecode
    import spi_nor_pkg::*;
#(
    parameter int               ID_LEN   = 3,
    parameter logic [REG_W-1:0] ID_BYTES = 48'h20BA19_000000
) (
    input  logic [7:0] op,
    input  logic       wel,
    input  logic       addr4,
    input  logic [7:0] seg,
    input  logic [7:0] vcfg,
    output dec_t       dec
);
    localparam logic [2:0] ID_N = 3'(ID_LEN);

    always_comb begin
        dec     = '0;
        dec.go  = GO_NONE;
        dec.act = ACT_NONE;
        dec.a4  = addr4;
        case (op)
            OP_WREN:  dec.wel_set = 1'b1;
            OP_WRDI:  dec.wel_clr = 1'b1;
            OP_EN4:   dec.a4_set  = 1'b1;
            OP_EX4:   dec.a4_clr  = 1'b1;
            OP_RSTEN: dec.rsten_req  = 1'b1;
            OP_RST:   dec.sreset_req = 1'b1;
            OP_RDSR: begin
                dec.go = GO_REGS; dec.rlen = 3'd1;
                dec.rbytes = {6'b0, wel, 1'b0, 40'b0};
            end
            OP_RDFSR: begin
                dec.go = GO_REGS; dec.rlen = 3'd1;
                dec.rbytes = {1'b1, 6'b0, addr4, 40'b0};
            end
            OP_RDID: begin
                dec.go = GO_REGS; dec.rlen = ID_N; dec.rbytes = ID_BYTES;
            end
            OP_RDSEG: begin
                dec.go = GO_REGS; dec.rlen = 3'd1; dec.rbytes = {seg, 40'b0};
            end
            OP_RDVC: begin
                dec.go = GO_REGS; dec.rlen = 3'd1; dec.rbytes = {vcfg, 40'b0};
            end
            OP_READ: begin
                dec.go = GO_COLLECT; dec.act = ACT_READ;
                dec.need = addr_bytes(addr4); dec.keep = addr_bytes(addr4)[2:0];
            end
            OP_FREAD: begin
                dec.go = GO_COLLECT; dec.act = ACT_READ;
                dec.need = addr_bytes(addr4) + {1'b0, vcfg[7:4]};
                dec.keep = addr_bytes(addr4)[2:0];
            end
            OP_PP: if (wel) begin
                dec.go = GO_COLLECT; dec.act = ACT_PROG;
                dec.need = addr_bytes(addr4); dec.keep = addr_bytes(addr4)[2:0];
            end
            OP_SE: if (wel) begin
                dec.go = GO_COLLECT; dec.act = ACT_ERASE;
                dec.need = addr_bytes(addr4); dec.keep = addr_bytes(addr4)[2:0];
            end
            OP_SE4: if (wel) begin
                dec.go = GO_COLLECT; dec.act = ACT_ERASE; dec.a4 = 1'b1;
                dec.need = 5'd4; dec.keep = 3'd4;
            end
            OP_WRSEG: if (wel) begin
                dec.go = GO_COLLECT; dec.act = ACT_SEG; dec.need = 5'd1; dec.keep = 3'd1;
            end
            OP_WRVC: if (wel) begin
                dec.go = GO_COLLECT; dec.act = ACT_VCFG; dec.need = 5'd1; dec.keep = 3'd1;
            end
            OP_WRSC: if (wel) begin
                dec.go = GO_VAR; dec.act = ACT_STATUS; dec.need = 5'd2; dec.keep = 3'd2;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_nor_cfgregs.sv
module spi_nor_cfgregs
    import spi_nor_pkg::*;
#(
    parameter logic [7:0] VCFG_RST = 8'h8B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_fire,
    input  dec_t       dec,
    input  logic       seg_we,
    input  logic [7:0] seg_d,
    input  logic       vcfg_we,
    input  logic [7:0] vcfg_d,
    input  logic       a4_we,
    input  logic       a4_d,
    output logic       wel,
    output logic       addr4,
    output logic [7:0] seg,
    output logic [7:0] vcfg
);
    logic rst_en;
    logic soft_rst;

    assign soft_rst = op_fire && dec.sreset_req && rst_en;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            wel    <= 1'b0;
            addr4  <= 1'b0;
            seg    <= '0;
            vcfg   <= VCFG_RST;
            rst_en <= 1'b0;
        end else begin
            if (op_fire) begin
                rst_en <= dec.rsten_req;
                if (dec.wel_set) wel <= 1'b1;
                if (dec.wel_clr) wel <= 1'b0;
                if (dec.a4_set)  addr4 <= 1'b1;
                if (dec.a4_clr)  addr4 <= 1'b0;
            end
            if (seg_we)  seg   <= seg_d;
            if (vcfg_we) vcfg  <= vcfg_d;
            if (a4_we)   addr4 <= a4_d;
        end
    end

    // R4: the segment register only moves when write enable was set, or back to zero by reset
    a_r4_seg_guarded: assert property (@(posedge clk) disable iff (rst)
        (seg != $past(seg)) |-> ($past(wel) || seg == 8'h00));
endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
    import spi_nor_pkg::*;
#(
    parameter int               SIZE_LOG2 = 25,
    parameter int               ID_LEN    = 3,
    parameter logic [REG_W-1:0] ID_BYTES  = 48'h20BA19_000000,
    parameter logic [7:0]       VCFG_RST  = 8'h8B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_active,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    output logic [7:0]           tx_byte,
    output logic [SIZE_LOG2-1:0] mem_addr,
    input  logic [7:0]           mem_rdata,
    output logic                 prog_valid,
    output logic [7:0]           prog_data,
    output logic                 erase_valid,
    output logic [SIZE_LOG2-1:0] erase_addr
);
    localparam int AW = SIZE_LOG2;

    seq_state_e       state;
    logic             used;
    logic [4:0]       cnt, need;
    logic [2:0]       keep;
    act_e             act;
    logic             cmd_a4;
    logic [31:0]      addr_sh;
    logic [AW-1:0]    cur_addr;
    logic [REG_W-1:0] rbuf;
    logic [2:0]       rlen, rpos;

    logic       wel, addr4;
    logic [7:0] seg, vcfg;
    dec_t       dec;

    logic        strobe, last, op_fire;
    logic [31:0] sh_in, eff32;
    logic        seg_we, vcfg_we, a4_we, a4_d;
    logic [7:0]  seg_d, vcfg_d;

    spi_nor_opdecode #(.ID_LEN(ID_LEN), .ID_BYTES(ID_BYTES)) u_dec (
        .op(rx_byte), .wel(wel), .addr4(addr4), .seg(seg), .vcfg(vcfg), .dec(dec)
    );

    spi_nor_cfgregs #(.VCFG_RST(VCFG_RST)) u_regs (
        .clk(clk), .rst(rst), .op_fire(op_fire), .dec(dec),
        .seg_we(seg_we), .seg_d(seg_d), .vcfg_we(vcfg_we), .vcfg_d(vcfg_d),
        .a4_we(a4_we), .a4_d(a4_d),
        .wel(wel), .addr4(addr4), .seg(seg), .vcfg(vcfg)
    );

    assign strobe  = cs_active && rx_valid;
    assign last    = (cnt + 5'd1) == need;
    assign op_fire = strobe && state == ST_IDLE && !used;
    assign sh_in   = ({2'b0, cnt} < {2'b0, keep}) ? {addr_sh[23:0], rx_byte} : addr_sh;
    assign eff32   = cmd_a4 ? sh_in : {seg, sh_in[23:0]};

    assign erase_addr  = eff32[AW-1:0];
    assign erase_valid = strobe && state == ST_COLLECT && last && act == ACT_ERASE;
    assign prog_valid  = strobe && state == ST_PROGRAM;
    assign prog_data   = rx_byte;
    assign mem_addr    = cur_addr;

    always_comb begin
        case (state)
            ST_READ:    tx_byte = mem_rdata;
            ST_REG_OUT: tx_byte = rbuf[REG_W-1 -: 8];
            default:    tx_byte = 8'h00;
        endcase
    end

    always_comb begin
        seg_we = 1'b0; seg_d = rx_byte;
        vcfg_we = 1'b0; vcfg_d = rx_byte;
        a4_we = 1'b0; a4_d = rx_byte[5];
        if (!cs_active) begin
            if (state == ST_COLLECT_VAR && cnt != 5'd0) begin
                vcfg_we = 1'b1;
                vcfg_d  = addr_sh[7:0];
            end
        end else if (rx_valid && last) begin
            if (state == ST_COLLECT) begin
                seg_we  = (act == ACT_SEG);
                vcfg_we = (act == ACT_VCFG);
            end else if (state == ST_COLLECT_VAR) begin
                vcfg_we = 1'b1;
                vcfg_d  = addr_sh[7:0];
                a4_we   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; used <= 1'b0; cnt <= '0; need <= '0; keep <= '0;
            act <= ACT_NONE; cmd_a4 <= 1'b0; addr_sh <= '0; cur_addr <= '0;
            rbuf <= '0; rlen <= '0; rpos <= '0;
        end else if (!cs_active) begin
            state <= ST_IDLE;
            used  <= 1'b0;
            cnt   <= '0;
        end else if (rx_valid) begin
            case (state)
                ST_IDLE: if (!used) begin
                    cnt <= '0; need <= dec.need; keep <= dec.keep;
                    act <= dec.act; cmd_a4 <= dec.a4; addr_sh <= '0;
                    case (dec.go)
                        GO_COLLECT: state <= ST_COLLECT;
                        GO_VAR:     state <= ST_COLLECT_VAR;
                        GO_REGS: begin
                            rbuf <= dec.rbytes; rlen <= dec.rlen; rpos <= '0;
                            if (dec.rlen == 3'd0) used <= 1'b1;
                            else                  state <= ST_REG_OUT;
                        end
                        default: used <= 1'b1;
                    endcase
                end
                ST_COLLECT, ST_COLLECT_VAR: begin
                    addr_sh <= sh_in;
                    cnt     <= cnt + 5'd1;
                    if (last) begin
                        if (state == ST_COLLECT && act == ACT_READ) begin
                            state <= ST_READ; cur_addr <= eff32[AW-1:0];
                        end else if (state == ST_COLLECT && act == ACT_PROG) begin
                            state <= ST_PROGRAM; cur_addr <= eff32[AW-1:0];
                        end else begin
                            state <= ST_IDLE; used <= 1'b1;
                        end
                    end
                end
                ST_REG_OUT: begin
                    rbuf <= rbuf << 8;
                    rpos <= rpos + 3'd1;
                    if (rpos + 3'd1 == rlen) begin
                        state <= ST_IDLE; used <= 1'b1;
                    end
                end
                default: cur_addr <= cur_addr + 1'b1;
            endcase
        end
    end

    // R12: a dropped chip select always lands in idle
    a_r12_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> state == ST_IDLE);
    // R11: no program pulse without the write-enable latch
    a_r11_prog_needs_wel: assert property (@(posedge clk) disable iff (rst)
        prog_valid |-> wel);
    // R10: no erase pulse without the write-enable latch
    a_r10_erase_needs_wel: assert property (@(posedge clk) disable iff (rst)
        erase_valid |-> wel);
    // R5: each read strobe steps the address by one, wrapping at the size
    a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && strobe) |=> mem_addr == $past(mem_addr) + 1'b1);
endmodule

// File: tb/spi_nor_seq_test.sv
`timescale 1ns/1ps
module spi_nor_seq_test;
    localparam int AW = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0;
    logic          rv = 1'b0;
    logic [7:0]    rb = 8'h00;
    logic [7:0]    tx_byte;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          prog_valid, erase_valid;
    logic [7:0]    prog_data;
    logic [AW-1:0] erase_addr;

    int nchk = 0, nfail = 0;
    logic [7:0]    l_tx;
    logic          l_pv, l_ev;
    logic [AW-1:0] l_pa, l_ea;
    logic [7:0]    l_pd;
    logic [7:0]    v;
    int            pcount, ecount;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ {a[14:8], 1'b1} ^ a[24:17];
    endfunction

    assign mem_rdata = memf(mem_addr);

    spi_nor_seq uut (
        .clk(clk), .rst(rst), .cs_active(cs), .rx_valid(rv), .rx_byte(rb),
        .tx_byte(tx_byte), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .prog_valid(prog_valid), .prog_data(prog_data),
        .erase_valid(erase_valid), .erase_addr(erase_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        cs = 1'b1; rv = 1'b1; rb = b;
        #1;
        l_tx = tx_byte; l_pv = prog_valid; l_pa = mem_addr; l_pd = prog_data;
        l_ev = erase_valid; l_ea = erase_addr;
        if (l_pv) pcount++;
        if (l_ev) ecount++;
        @(posedge clk);
        #1 rv = 1'b0;
    endtask

    task automatic endf();
        @(negedge clk);
        cs = 1'b0; rv = 1'b0;
        @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        xfer(op); endf();
    endtask

    task automatic rdreg(input logic [7:0] op, output logic [7:0] val);
        xfer(op); xfer(8'h00); val = l_tx; endf();
    endtask

    task automatic wr1(input logic [7:0] op, input logic [7:0] d);
        xfer(op); xfer(d); endf();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        pcount = 0; ecount = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 tx after reset", 32'(tx_byte), 32'h00);
        rdreg(8'h05, v); chk("R1 status after reset", 32'(v), 32'h00);
        rdreg(8'h70, v); chk("R1 R3 flag after reset", 32'(v), 32'h80);
        rdreg(8'hC8, v); chk("R1 segment after reset", 32'(v), 32'h00);
        rdreg(8'h85, v); chk("R1 vcfg after reset", 32'(v), 32'h8B);

        // R2 and R13
        xfer(8'h06); chk("R13 opcode strobe returns zero", 32'(l_tx), 32'h00); endf();
        rdreg(8'h05, v); chk("R2 status after set", 32'(v), 32'h02);
        op1(8'h04);
        rdreg(8'h05, v); chk("R2 status after clear", 32'(v), 32'h00);

        // R7
        xfer(8'h9F);
        xfer(8'h00); chk("R7 id byte 0", 32'(l_tx), 32'h20);
        xfer(8'h00); chk("R7 id byte 1", 32'(l_tx), 32'hBA);
        xfer(8'h00); chk("R7 id byte 2", 32'(l_tx), 32'h19);
        xfer(8'h00); chk("R7 past id length", 32'(l_tx), 32'h00);
        endf();

        // R5 sweep of 3-byte reads
        for (int s = 0; s < 4; s++) begin
            logic [23:0] a;
            a = 24'h123456 + 24'(s * 24'h0F0F1);
            if (s == 3) a = 24'hFFFFFD;
            xfer(8'h03); xfer(a[23:16]); xfer(a[15:8]);
            xfer(a[7:0]); chk("R13 last address strobe returns zero", 32'(l_tx), 32'h00);
            for (int i = 0; i < 6; i++) begin
                xfer(8'h00);
                chk("R5 read stream", 32'(l_tx), 32'(memf(AW'(a) + AW'(i))));
            end
            endf();
        end

        // R4 segment register
        wr1(8'hC5, 8'h01);
        rdreg(8'hC8, v); chk("R4 segment write ignored without latch", 32'(v), 32'h00);
        op1(8'h06);
        wr1(8'hC5, 8'h01);
        rdreg(8'hC8, v); chk("R4 segment written", 32'(v), 32'h01);
        xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h10); xfer(8'h00);
        chk("R4 segment offsets address", 32'(l_tx), 32'(memf(25'h1000010)));
        endf();
        xfer(8'h03); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
        xfer(8'h00); chk("R5 top byte", 32'(l_tx), 32'(memf(25'h1FFFFFF)));
        xfer(8'h00); chk("R5 wrap to zero", 32'(l_tx), 32'(memf(25'h0)));
        endf();

        // R6 dummy byte sweep
        for (int d = 0; d < 4; d++) begin
            wr1(8'h81, 8'(d << 4));
            rdreg(8'h85, v); chk("R6 vcfg readback", 32'(v), 32'(d << 4));
            xfer(8'h0B); xfer(8'h00); xfer(8'h20); xfer(8'h00);
            for (int k = 0; k < d; k++) begin
                xfer(8'hA5); chk("R6 dummy strobe returns zero", 32'(l_tx), 32'h00);
            end
            xfer(8'h00); chk("R6 first data after dummies", 32'(l_tx), 32'(memf(25'h1002000)));
            xfer(8'h00); chk("R6 second data", 32'(l_tx), 32'(memf(25'h1002001)));
            endf();
        end

        // R3 4-byte mode
        op1(8'hB7);
        rdreg(8'h70, v); chk("R3 flag in 4-byte mode", 32'(v), 32'h81);
        xfer(8'h03); xfer(8'h01); xfer(8'hFF); xfer(8'hFF); xfer(8'hFE);
        xfer(8'h00); chk("R5 4-byte read", 32'(l_tx), 32'(memf(25'h1FFFFFE)));
        xfer(8'h00); chk("R5 4-byte read next", 32'(l_tx), 32'(memf(25'h1FFFFFF)));
        xfer(8'h00); chk("R5 4-byte wrap", 32'(l_tx), 32'(memf(25'h0)));
        endf();
        op1(8'hE9);
        rdreg(8'h70, v); chk("R3 flag back to 3-byte", 32'(v), 32'h80);

        // R10 erase
        op1(8'h04);
        ecount = 0;
        xfer(8'hD8); xfer(8'h00); xfer(8'h12); xfer(8'h34); endf();
        chk("R10 no erase without latch", 32'(ecount), 32'd0);
        op1(8'h06);
        xfer(8'hD8); xfer(8'h00); xfer(8'h12); xfer(8'h34);
        chk("R10 erase pulse", 32'(l_ev), 32'd1);
        chk("R10 erase address 3-byte", 32'(l_ea), 32'h1001234);
        endf();
        xfer(8'hDC); xfer(8'h00); xfer(8'h00); xfer(8'h12); xfer(8'h34);
        chk("R10 erase address 4-byte form", 32'(l_ea), 32'h0001234);
        endf();

        // R11 program
        pcount = 0;
        xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h40);
        for (int i = 0; i < 5; i++) begin
            xfer(8'(8'hC0 + i));
            chk("R11 program address", 32'(l_pa), 32'(25'h1000040 + i));
            chk("R11 program data", 32'(l_pd), 32'(8'hC0 + i));
        end
        endf();
        chk("R11 program pulse count", 32'(pcount), 32'd5);
        op1(8'h04);
        pcount = 0;
        xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h40); xfer(8'h11); xfer(8'h22); endf();
        chk("R11 no program without latch", 32'(pcount), 32'd0);

        // R8 reset handshake
        op1(8'h06); op1(8'hB7); wr1(8'hC5, 8'h02);
        op1(8'h99);
        rdreg(8'h05, v); chk("R8 reset ignored without enable", 32'(v), 32'h02);
        op1(8'h66); op1(8'h05); op1(8'h99);
        rdreg(8'h05, v); chk("R8 reset ignored after other opcode", 32'(v), 32'h02);
        op1(8'h66); op1(8'h99);
        rdreg(8'h05, v); chk("R8 latch cleared by reset", 32'(v), 32'h00);
        rdreg(8'h70, v); chk("R8 mode cleared by reset", 32'(v), 32'h80);
        rdreg(8'hC8, v); chk("R8 segment cleared by reset", 32'(v), 32'h00);
        rdreg(8'h85, v); chk("R8 vcfg restored by reset", 32'(v), 32'h8B);

        // R9 variable-length write
        op1(8'h06);
        wr1(8'h01, 8'h30);
        rdreg(8'h85, v); chk("R9 one byte committed on deselect", 32'(v), 32'h30);
        rdreg(8'h70, v); chk("R9 mode untouched by one byte", 32'(v), 32'h80);
        xfer(8'h01); xfer(8'h40); xfer(8'h20); xfer(8'h55); endf();
        rdreg(8'h85, v); chk("R9 two byte commit vcfg", 32'(v), 32'h40);
        rdreg(8'h70, v); chk("R9 two byte commit mode", 32'(v), 32'h81);
        xfer(8'h01); xfer(8'h50); xfer(8'h00); endf();
        rdreg(8'h70, v); chk("R9 mode cleared by byte 1", 32'(v), 32'h80);
        op1(8'h04);
        wr1(8'h01, 8'h77);
        rdreg(8'h85, v); chk("R9 ignored without latch", 32'(v), 32'h50);

        // R12 ignored bytes
        xfer(8'hAB); xfer(8'h05); xfer(8'h00);
        chk("R12 unknown opcode swallows frame", 32'(l_tx), 32'h00); endf();
        xfer(8'h06); xfer(8'h04); endf();
        rdreg(8'h05, v); chk("R12 second opcode in frame ignored", 32'(v), 32'h02);
        xfer(8'h03); xfer(8'h12); endf();
        rdreg(8'h05, v); chk("R12 deselect mid-address returns to idle", 32'(v), 32'h02);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule